// File: doc/BRIEF.md
# Delay-Line Bring-Up and Lock Sequencer

This block prepares a sampling delay line for read-timing calibration on a memory-card host port. A single-cycle `start_i` pulse tells it the current card clock in MHz and the bus signalling mode. From these it decides whether calibration is needed. If it is not, it reports "skipped" on the next cycle and touches nothing. If it is, it first turns off the clock power-save bit so that the card clock cannot stop. It then walks the delay-line configuration image through a fixed sequence of single-bit steps: assert reset, assert power-down, load the frequency band, release reset, release power-down, enable the line, and enable the clock output. After that it polls the delay line's lock flag, which reaches it through a synchroniser.

Once the line is locked, the block raises a sweep request. An external phase sweeper answers with a done strobe and a pass flag that says whether any phase passed. A failed sweep restarts the whole bring-up, and there are at most three attempts in total. The block then pulses `done_o` with a 2-bit result code. All pins are plain control and status pins. The sweep request is a level that is held until it is acknowledged, so it has no back-pressure beyond that acknowledgement.

Top module: `dll_lock_seq`

## Requirements
- R1: After reset, `dll_cfg_o` is 0, `pwrsave_o` is 1, and `busy_o`, `done_o` and `sweep_req_o` are all 0.
- R2: A start is treated as "no calibration needed" when the clock is at most 100 MHz, or when `bus_mode_i` is neither 4 (SDR104) nor 5 (HS200). In that case `done_o` pulses in the cycle after the start edge with `result_o` = 1 (skip), and `dll_cfg_o`, `pwrsave_o` and `sweep_req_o` do not change.
- R3: The first step of every attempt clears `pwrsave_o`, one cycle before any change to `dll_cfg_o`. `dll_cfg_o` never changes while `pwrsave_o` is 1.
- R4: Counting cycles k after the start edge, each attempt applies exactly one step per cycle. With R = bit 30 (reset), P = bit 29 (power-down), E = bit 16 (enable) and C = bit 18 (clock output), the steps are: k=1 clear power-save, k=2 set R, k=3 set P, k=4 load band, k=5 clear R, k=6 clear P, k=7 set E, k=8 set C.
- R5: The band field at bits 26:24 holds the count of the thresholds 112, 125, 137, 150, 162, 175 and 187 MHz that the clock exceeds. A clock above 200 MHz therefore gives 7.
- R6: After C is set, the synchronised lock flag is polled once every CLK_PER_US cycles, for at most MAX_POLLS polls. If none of the polls sees lock, `done_o` pulses with `result_o` = 2 (timeout) at k = 8 + MAX_POLLS*CLK_PER_US, and no sweep is requested.
- R7: Once lock is seen, `sweep_req_o` is held high until `sweep_done_i`. If `sweep_pass_i` is 1 on that strobe, `done_o` pulses with `result_o` = 0 (ok).
- R8: A sweep strobe with `sweep_pass_i` = 0 restarts the sequence from the power-save step. After MAX_TRIES failed sweeps, `done_o` pulses with `result_o` = 3 (I/O error).
- R9: `start_i` is ignored while `busy_o` is 1.
- R10: `done_o` is high for exactly one cycle, with `busy_o` low, and `result_o` keeps its value until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| clk_mhz_i | input | MHZ_W | Card clock frequency in MHz, sampled on start |
| bus_mode_i | input | 3 | Bus signalling mode code (4 = SDR104, 5 = HS200) |
| lock_i | input | 1 | Asynchronous lock flag from the delay line |
| sweep_done_i | input | 1 | Sweep finished strobe |
| sweep_pass_i | input | 1 | Some phase passed in the finished sweep |
| dll_cfg_o | output | 32 | Delay-line configuration image |
| pwrsave_o | output | 1 | Clock power-save enable |
| sweep_req_o | output | 1 | Request to run a phase sweep |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 skip, 2 lock timeout, 3 I/O error |

## Verification
The bench probes the skip boundary at exactly 100 MHz, where a wrong comparison would start a calibration, and HS400 mode at 200 MHz, which a loose mode decode would calibrate. Band edges at 112/113 and 187/188 MHz, and the clamp above 200 MHz, expose an off-by-one or a wrapped band field. Per-cycle checks of the configuration image catch a swapped release order, or an enable that is set while reset is still asserted. A lock that never arrives must time out at a precise cycle. This catches poll counters that stop one poll early or one poll late. Sweep failure patterns that pass on the second or third try, or never pass, check the retry count, and a start pulse injected mid-run must not restart the sequencer.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  localparam int CFG_W     = 32;
  localparam int BIT_RST   = 30;
  localparam int BIT_PDN   = 29;
  localparam int BIT_EN    = 16;
  localparam int BIT_CKO   = 18;
  localparam int BAND_LSB  = 24;
  localparam int BAND_W    = 3;
  localparam int N_EDGES   = 7;

  localparam int unsigned BAND_EDGE [N_EDGES] = '{112, 125, 137, 150, 162, 175, 187};

  localparam logic [2:0] MODE_SDR104 = 3'd4;
  localparam logic [2:0] MODE_HS200  = 3'd5;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_SKIP    = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_IOERR   = 2'd3
  } res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PS_OFF,
    ST_RST_ON,
    ST_PDN_ON,
    ST_BAND,
    ST_RST_OFF,
    ST_PDN_OFF,
    ST_EN_ON,
    ST_CKO_ON,
    ST_WAIT,
    ST_SWEEP
  } step_e;
endpackage

// File: rtl/dll_band_enc.sv
module dll_band_enc
  import dll_seq_pkg::*;
#(
  parameter int MHZ_W = 10
)(
  input  logic [MHZ_W-1:0]  mhz_i,
  output logic [BAND_W-1:0] band_o
);
  logic [N_EDGES-1:0] above;

  for (genvar g = 0; g < N_EDGES; g++) begin : g_edge
    assign above[g] = (mhz_i > MHZ_W'(BAND_EDGE[g]));
  end

  always_comb band_o = BAND_W'($countones(above));
endmodule

// File: rtl/dll_sync.sv
module dll_sync #(
  parameter int STAGES = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dll_poll_timer.sv
module dll_poll_timer #(
  parameter int CLK_PER_US = 50,
  parameter int MAX_POLLS  = 50
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);
  localparam int UW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [UW-1:0] us_cnt;
  logic [PW-1:0] poll_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt   <= UW'(CLK_PER_US - 1);
      poll_cnt <= '0;
    end else if (!run_i) begin
      us_cnt   <= UW'(CLK_PER_US - 1);
      poll_cnt <= '0;
    end else if (us_cnt == '0) begin
      us_cnt   <= UW'(CLK_PER_US - 1);
      poll_cnt <= poll_cnt + 1'b1;
    end else begin
      us_cnt   <= us_cnt - 1'b1;
    end
  end

  assign tick_o = run_i && (us_cnt == '0);
  assign last_o = tick_o && (poll_cnt == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dll_seq_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int MAX_POLLS   = 50,
  parameter int MAX_TRIES   = 3,
  parameter int MHZ_W       = 10,
  parameter int SKIP_MHZ    = 100,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [MHZ_W-1:0] clk_mhz_i,
  input  logic [2:0]       bus_mode_i,
  input  logic             lock_i,
  input  logic             sweep_done_i,
  input  logic             sweep_pass_i,
  output logic [31:0]      dll_cfg_o,
  output logic             pwrsave_o,
  output logic             sweep_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  step_e              state;
  logic [CFG_W-1:0]   cfg_q;
  logic               ps_q;
  logic [MHZ_W-1:0]   mhz_q;
  logic [TW-1:0]      tries_q;
  logic               done_q;
  res_e               res_q;
  logic [BAND_W-1:0]  band;
  logic               lock_s;
  logic               tick, last_poll;
  logic               need_tune;

  dll_band_enc #(.MHZ_W(MHZ_W)) u_band (
    .mhz_i  (mhz_q),
    .band_o (band)
  );

  dll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lock_i),
    .q_o   (lock_s)
  );

  dll_poll_timer #(.CLK_PER_US(CLK_PER_US), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state == ST_WAIT),
    .tick_o (tick),
    .last_o (last_poll)
  );

  assign need_tune = (clk_mhz_i > MHZ_W'(SKIP_MHZ)) &&
                     ((bus_mode_i == MODE_SDR104) || (bus_mode_i == MODE_HS200));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cfg_q   <= '0;
      ps_q    <= 1'b1;
      mhz_q   <= '0;
      tries_q <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            if (need_tune) begin
              mhz_q   <= clk_mhz_i;
              tries_q <= '0;
              state   <= ST_PS_OFF;
            end else begin
              done_q <= 1'b1;
              res_q  <= RES_SKIP;
            end
          end
        end
        ST_PS_OFF: begin
          ps_q  <= 1'b0;
          state <= ST_RST_ON;
        end
        ST_RST_ON: begin
          cfg_q[BIT_RST] <= 1'b1;
          state          <= ST_PDN_ON;
        end
        ST_PDN_ON: begin
          cfg_q[BIT_PDN] <= 1'b1;
          state          <= ST_BAND;
        end
        ST_BAND: begin
          cfg_q[BAND_LSB +: BAND_W] <= band;
          state                     <= ST_RST_OFF;
        end
        ST_RST_OFF: begin
          cfg_q[BIT_RST] <= 1'b0;
          state          <= ST_PDN_OFF;
        end
        ST_PDN_OFF: begin
          cfg_q[BIT_PDN] <= 1'b0;
          state          <= ST_EN_ON;
        end
        ST_EN_ON: begin
          cfg_q[BIT_EN] <= 1'b1;
          state         <= ST_CKO_ON;
        end
        ST_CKO_ON: begin
          cfg_q[BIT_CKO] <= 1'b1;
          state          <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tick) begin
            if (lock_s) begin
              state <= ST_SWEEP;
            end else if (last_poll) begin
              done_q <= 1'b1;
              res_q  <= RES_TIMEOUT;
              state  <= ST_IDLE;
            end
          end
        end
        ST_SWEEP: begin
          if (sweep_done_i) begin
            if (sweep_pass_i) begin
              done_q <= 1'b1;
              res_q  <= RES_OK;
              state  <= ST_IDLE;
            end else if (tries_q == TW'(MAX_TRIES - 1)) begin
              done_q <= 1'b1;
              res_q  <= RES_IOERR;
              state  <= ST_IDLE;
            end else begin
              tries_q <= tries_q + 1'b1;
              state   <= ST_PS_OFF;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dll_cfg_o   = cfg_q;
  assign pwrsave_o   = ps_q;
  assign sweep_req_o = (state == ST_SWEEP);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
endmodule

// File: rtl/dll_lock_seq_chk.sv
module dll_lock_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sweep_done_i,
  input logic [31:0] dll_cfg_o,
  input logic        pwrsave_o,
  input logic        sweep_req_o,
  input logic        busy_o,
  input logic        done_o
);
  a_r3_cfg_moves_only_without_pwrsave: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dll_cfg_o) |-> !pwrsave_o);

  a_r4_cko_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_cfg_o[18]) |-> (!dll_cfg_o[30] && !dll_cfg_o[29] && dll_cfg_o[16]));

  a_r4_single_ctrl_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dll_cfg_o[30], dll_cfg_o[29], dll_cfg_o[18], dll_cfg_o[16]}) |->
      $countones({dll_cfg_o[30], dll_cfg_o[29], dll_cfg_o[18], dll_cfg_o[16]} ^
                 $past({dll_cfg_o[30], dll_cfg_o[29], dll_cfg_o[18], dll_cfg_o[16]})) == 1);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_req_o && !sweep_done_i) |=> sweep_req_o);

  a_r7_req_needs_live_dll: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_req_o |-> (dll_cfg_o[16] && dll_cfg_o[18] && !dll_cfg_o[30] && !dll_cfg_o[29]));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind dll_lock_seq dll_lock_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sweep_done_i (sweep_done_i),
  .dll_cfg_o    (dll_cfg_o),
  .pwrsave_o    (pwrsave_o),
  .sweep_req_o  (sweep_req_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/dll_lock_seq_bench.sv
module dll_lock_seq_bench;
  localparam int US    = 4;
  localparam int POLLS = 50;
  localparam int TRIES = 3;
  localparam int MW    = 10;
  localparam int LIMIT = TRIES * (POLLS * US + 40) + 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [MW-1:0] clk_mhz_i = '0;
  logic [2:0]    bus_mode_i = '0;
  logic          lock_i = 1'b0;
  logic          sweep_done_i = 1'b0;
  logic          sweep_pass_i = 1'b0;
  logic [31:0]   dll_cfg_o;
  logic          pwrsave_o, sweep_req_o, busy_o, done_o;
  logic [1:0]    result_o;

  int nchk = 0;
  int nerr = 0;
  int lock_dly = 0;
  bit lock_never = 1'b0;
  int lock_cnt = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dll_lock_seq #(.CLK_PER_US(US), .MAX_POLLS(POLLS), .MAX_TRIES(TRIES), .MHZ_W(MW)) u_dll_lock_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_mhz_i(clk_mhz_i),
    .bus_mode_i(bus_mode_i), .lock_i(lock_i), .sweep_done_i(sweep_done_i),
    .sweep_pass_i(sweep_pass_i), .dll_cfg_o(dll_cfg_o), .pwrsave_o(pwrsave_o),
    .sweep_req_o(sweep_req_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // Delay-line model: lock rises lock_dly cycles after the line is enabled and out of reset.
  always @(posedge clk) begin
    if (!(dll_cfg_o[16] && dll_cfg_o[18] && !dll_cfg_o[30] && !dll_cfg_o[29])) begin
      lock_cnt <= 0;
      lock_i   <= 1'b0;
    end else if (!lock_never && lock_cnt >= lock_dly) begin
      lock_i <= 1'b1;
    end else begin
      lock_cnt <= lock_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int band_of(input int mhz);
    if (mhz <= 112) return 0;
    else if (mhz <= 125) return 1;
    else if (mhz <= 137) return 2;
    else if (mhz <= 150) return 3;
    else if (mhz <= 162) return 4;
    else if (mhz <= 175) return 5;
    else if (mhz <= 187) return 6;
    return 7;
  endfunction

  task automatic run_case(input int mhz, input int mode, input int dly, input bit never,
                          input bit [2:0] pass, input bit poke);
    logic [31:0] base, img;
    logic [31:0] exp_img [9];
    bit          base_ps, need, got_done, seq_ok;
    int          exp_res, exp_sweeps, sweeps, k, done_at;

    base    = dll_cfg_o;
    base_ps = pwrsave_o;
    need    = (mhz > 100) && (mode == 4 || mode == 5);
    exp_sweeps = 0;
    if (!need) exp_res = 1;
    else if (never) exp_res = 2;
    else begin
      exp_res = 3; exp_sweeps = 3;
      for (int i = 2; i >= 0; i--) if (pass[i]) begin exp_res = 0; exp_sweeps = i + 1; end
    end
    img = base;
    exp_img[0] = img; exp_img[1] = img;
    img[30] = 1'b1; exp_img[2] = img;
    img[29] = 1'b1; exp_img[3] = img;
    img[26:24] = 3'(band_of(mhz)); exp_img[4] = img;
    img[30] = 1'b0; exp_img[5] = img;
    img[29] = 1'b0; exp_img[6] = img;
    img[16] = 1'b1; exp_img[7] = img;
    img[18] = 1'b1; exp_img[8] = img;

    clk_mhz_i = MW'(mhz); bus_mode_i = 3'(mode);
    lock_dly = dly; lock_never = never; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    k = 0; sweeps = 0; got_done = 1'b0; done_at = -1; seq_ok = 1'b1;
    while (!got_done && k < LIMIT) begin
      if (need && sweeps == 0 && k >= 1 && k <= 8) begin
        if (dll_cfg_o !== exp_img[k]) seq_ok = 1'b0;
        if (pwrsave_o !== 1'b0) seq_ok = 1'b0;
      end
      if (poke && k == 20) begin start_i = 1'b1; clk_mhz_i = MW'(250); end
      else start_i = 1'b0;
      if (sweep_done_i) sweep_done_i = 1'b0;
      else if (sweep_req_o) begin
        sweeps++;
        sweep_done_i = 1'b1;
        sweep_pass_i = (sweeps <= 3) ? pass[sweeps-1] : 1'b1;
      end
      if (done_o) begin got_done = 1'b1; done_at = k; end
      else begin @(posedge clk); @(negedge clk); k++; end
    end
    start_i = 1'b0;
    check(got_done, "R10 run completes", got_done, 1);
    check(result_o == 2'(exp_res), "R2/R6/R7/R8 result code", result_o, exp_res);
    check(sweeps == exp_sweeps, "R8 sweep count", sweeps, exp_sweeps);
    if (!need) begin
      check(done_at == 0, "R2 skip reported next cycle", done_at, 0);
      check(dll_cfg_o == base && pwrsave_o == base_ps, "R2 skip leaves cfg and pwrsave",
            {pwrsave_o, dll_cfg_o}, {base_ps, base});
    end else begin
      check(seq_ok, "R4 step sequence and R3 pwrsave first", dll_cfg_o, exp_img[8]);
      check(dll_cfg_o[26:24] == 3'(band_of(mhz)), "R5 band code", dll_cfg_o[26:24], band_of(mhz));
      if (never)
        check(done_at == 8 + POLLS * US, "R6 timeout cycle", done_at, 8 + POLLS * US);
    end
    @(posedge clk); @(negedge clk);
    check(!done_o && !busy_o && result_o == 2'(exp_res), "R10 single pulse, result held",
          {done_o, busy_o, result_o}, exp_res);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(dll_cfg_o == 0 && pwrsave_o && !busy_o && !done_o && !sweep_req_o, "R1 reset state",
          {dll_cfg_o, pwrsave_o, busy_o, done_o, sweep_req_o}, 32'h0 << 4 | 4'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(dll_cfg_o == 0 && pwrsave_o && !busy_o, "R1 state after release",
          {dll_cfg_o, pwrsave_o, busy_o}, 2'b10);

    run_case(100, 5, 0, 1'b0, 3'b001, 1'b0);   // R2 boundary: exactly 100 MHz
    run_case(200, 6, 0, 1'b0, 3'b001, 1'b0);   // R2 HS400 is not calibrated
    run_case(101, 4, 0, 1'b0, 3'b001, 1'b0);   // R5 band 0, R7 ok
    run_case(113, 5, 5, 1'b0, 3'b001, 1'b0);   // R5 band 1 edge
    run_case(187, 4, 9, 1'b0, 3'b001, 1'b0);   // R5 band 6 edge
    run_case(188, 4, 9, 1'b0, 3'b001, 1'b0);   // R5 band 7 edge
    run_case(250, 5, 3, 1'b0, 3'b001, 1'b0);   // R5 clamp above 200
    run_case(150, 5, 2, 1'b0, 3'b100, 1'b0);   // R8 pass on third try
    run_case(160, 4, 2, 1'b0, 3'b000, 1'b0);   // R8 I/O error
    run_case(140, 5, 0, 1'b1, 3'b001, 1'b0);   // R6 lock timeout
    run_case(130, 5, (POLLS - 1) * US, 1'b0, 3'b001, 1'b0); // R6 late lock still accepted
    run_case(130, 4, 120, 1'b0, 3'b010, 1'b1); // R9 start mid-run ignored
    run_case(90, 5, 0, 1'b0, 3'b001, 1'b0);    // R2 skip after a tuned run

    for (int n = 0; n < 30; n++) begin
      int mhz, mode, dly;
      bit never;
      bit [2:0] pass;
      mhz   = 60 + int'($urandom_range(0, 200));
      mode  = ($urandom_range(0, 3) != 0) ? int'($urandom_range(4, 5)) : int'($urandom_range(0, 7));
      dly   = int'($urandom_range(0, (POLLS - 1) * US));
      never = ($urandom_range(0, 7) == 0);
      pass  = 3'($urandom_range(0, 7));
      run_case(mhz, mode, dly, never, pass, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule